// File: doc/BRIEF.md
# Indirect Post-Increment Move Sequencer

This block carries out one memory-indirect move with an automatic pointer bump. The caller gives it an operand address, which names a memory byte that holds a pointer. The block reads that pointer and uses it as the effective address. In load mode it copies the byte at the pointer into the accumulator. In store mode it writes the accumulator to the byte at the pointer. It then writes the pointer plus one back to the operand address. The pointer wraps within 8 bits.

The sequencer drives a single-port synchronous data memory. It issues at most one access per cycle, and read data comes back the cycle after the address is presented. A move is started by a one-cycle `start_i` pulse and always takes a fixed number of cycles, ten by default. That count is the latency of the two-byte pointer-move opcodes, 0x3E for load and 0x3F for store. Opcode decode happens outside this block, which receives only the direction bit.

The direction, the operand address and the accumulator value are all captured on the clock edge that accepts `start_i`. The accumulator result leaves the block as a one-cycle write strobe with its data. `rst_n` is asynchronous and active-low, and it must already be released synchronously to `clk`.

Top module: `ipi_move_seq`

## Requirements
- R1: During and right after reset, `busy_o`, `done_o`, `mem_en_o` and `acc_we_o` are 0, and no memory access or accumulator strobe happens while `busy_o` is 0.
- R2: In the first cycle after the edge that accepts `start_i`, the block issues a read (`mem_en_o`=1, `mem_we_o`=0) of the operand address.
- R3: Load (`dir_store_i`=0): the accumulator receives the byte that was stored at the pointer address.
- R4: Store (`dir_store_i`=1): the byte at the pointer address becomes the accumulator value present at the accepting edge. Later changes on `acc_i` have no effect.
- R5: At the end of the move, the operand location holds the old pointer plus one modulo 256, so 0xFF becomes 0x00.
- R6: `done_o` is high for exactly one cycle, the 10th cycle of the move. Cycle 1 is the cycle right after the accepting edge. `busy_o` falls at the end of that cycle.
- R7: A `start_i` pulse while `busy_o` is 1 is ignored. The running move completes unchanged, and no extra move or `done_o` follows.
- R8: The pointer write-back is the last memory write of a move. A load performs exactly one write and a store exactly two.
- R9: In a store where the pointer equals the operand address, the accumulator is written first and the incremented pointer then overwrites it. The location ends as pointer plus one.
- R10: A store never asserts `acc_we_o`, and a load writes memory only at the operand address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | One-cycle request to begin a move |
| dir_store_i | input | 1 | 1 = store accumulator, 0 = load accumulator |
| opnd_addr_i | input | 8 | Address of the memory byte holding the pointer |
| acc_i | input | 8 | Current accumulator value |
| acc_we_o | output | 1 | Accumulator write strobe (load only) |
| acc_wdata_o | output | 8 | Value to write into the accumulator |
| mem_en_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 8 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after a read |
| busy_o | output | 1 | Move in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench targets these corner cases, each with the fault it would expose:
- Pointer 0xFF, where a design with a wide adder or a missing wrap would leave the wrong byte behind.
- Pointer equal to the operand address. A store that wrote in the wrong order would leave the accumulator there instead of pointer+1. A load would then return the pointer itself.
- Repeated loads through one operand. These catch a design that bumps the pointer before using it, because the loaded values would shift by one element.
- `acc_i` changing after acceptance. This exposes a store that samples the accumulator late.
- A second start pulse mid-move. This catches a restart, a changed result or a second done pulse.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  // Step of a move, decoded from the cycle counter.
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PTR_RD,    // read pointer at operand address
    PH_PTR_CAP,   // pointer returns on read data, captured at end of cycle
    PH_DATA,      // access data at pointer (read or write)
    PH_LOAD_CAP,  // load data returns, accumulator strobe
    PH_PTR_WB,    // write pointer+1 to operand address
    PH_PAD,       // latency padding
    PH_DONE       // final cycle, done pulse
  } phase_e;

  localparam int unsigned MIN_CYCLES = 6;

endpackage

// File: rtl/ipi_phase_ctr.sv
module ipi_phase_ctr
  import ipi_pkg::*;
#(
  parameter int unsigned CYCLES = 10
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  output logic   accept_o,
  output logic   busy_o,
  output phase_e phase_o
);

  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          cnt_en;

  assign accept_o = start_i && !busy_q;
  assign cnt_en   = accept_o || busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        cnt_d  = '0;
      end
    end else if (cnt_q == LAST) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  always_comb begin
    if (!busy_q) begin
      phase_o = PH_IDLE;
    end else if (cnt_q == LAST) begin
      phase_o = PH_DONE;
    end else begin
      case (cnt_q)
        CW'(0):  phase_o = PH_PTR_RD;
        CW'(1):  phase_o = PH_PTR_CAP;
        CW'(2):  phase_o = PH_DATA;
        CW'(3):  phase_o = PH_LOAD_CAP;
        CW'(4):  phase_o = PH_PTR_WB;
        default: phase_o = PH_PAD;
      endcase
    end
  end

  assign busy_o = busy_q;

  // R6: final cycle lasts exactly one cycle
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_DONE) |=> (phase_o != PH_DONE));

  // R7: a running move only advances; a start pulse cannot rewind it
  p_cnt_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (cnt_q != LAST)) |=> (busy_q && (cnt_q == $past(cnt_q) + 1'b1)));

  // R6: the move ends right after the final cycle
  p_busy_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_DONE) |=> !busy_q);

endmodule

// File: rtl/ipi_ptr_unit.sv
module ipi_ptr_unit #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [W-1:0] rdata_i,
  output logic [W-1:0] ptr_o,
  output logic [W-1:0] ptr_inc_o
);

  logic [W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (cap_en) ptr_d = rdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (cap_en) ptr_q <= ptr_d;
  end

  // Increment stays within W bits, so the all-ones pointer wraps to zero.
  assign ptr_o     = ptr_q;
  assign ptr_inc_o = ptr_q + W'(1);

endmodule

// File: rtl/ipi_bus_drv.sv
module ipi_bus_drv
  import ipi_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  phase_e       phase_i,
  input  logic         store_i,
  input  logic [W-1:0] opnd_i,
  input  logic [W-1:0] ptr_i,
  input  logic [W-1:0] ptr_inc_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] rdata_i,
  output logic         mem_en_o,
  output logic         mem_we_o,
  output logic [W-1:0] mem_addr_o,
  output logic [W-1:0] mem_wdata_o,
  output logic         acc_we_o,
  output logic [W-1:0] acc_wdata_o,
  output logic         ptr_cap_o
);

  always_comb begin
    mem_en_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = opnd_i;
    mem_wdata_o = '0;
    acc_we_o    = 1'b0;
    acc_wdata_o = rdata_i;
    ptr_cap_o   = 1'b0;
    case (phase_i)
      PH_PTR_RD: begin
        mem_en_o   = 1'b1;
        mem_addr_o = opnd_i;
      end
      PH_PTR_CAP: begin
        ptr_cap_o = 1'b1;
      end
      PH_DATA: begin
        mem_en_o    = 1'b1;
        mem_we_o    = store_i;
        mem_addr_o  = ptr_i;
        mem_wdata_o = acc_i;
      end
      PH_LOAD_CAP: begin
        acc_we_o = !store_i;
      end
      PH_PTR_WB: begin
        mem_en_o    = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = opnd_i;
        mem_wdata_o = ptr_inc_i;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ipi_move_seq.sv
module ipi_move_seq
  import ipi_pkg::*;
#(
  parameter int unsigned CYCLES = 10  // at least ipi_pkg::MIN_CYCLES
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       dir_store_i,
  input  logic [7:0] opnd_addr_i,
  input  logic [7:0] acc_i,
  output logic       acc_we_o,
  output logic [7:0] acc_wdata_o,
  output logic       mem_en_o,
  output logic       mem_we_o,
  output logic [7:0] mem_addr_o,
  output logic [7:0] mem_wdata_o,
  input  logic [7:0] mem_rdata_i,
  output logic       busy_o,
  output logic       done_o
);

  localparam int unsigned W = 8;

  logic         accept;
  phase_e       phase;
  logic         ptr_cap;
  logic [W-1:0] ptr, ptr_inc;

  logic         store_q, store_d;
  logic [W-1:0] opnd_q, opnd_d;
  logic [W-1:0] acc_q, acc_d;

  ipi_phase_ctr #(.CYCLES(CYCLES)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept_o (accept),
    .busy_o   (busy_o),
    .phase_o  (phase)
  );

  // Request fields are captured on the accepting edge only.
  always_comb begin
    store_d = store_q;
    opnd_d  = opnd_q;
    acc_d   = acc_q;
    if (accept) begin
      store_d = dir_store_i;
      opnd_d  = opnd_addr_i;
      acc_d   = acc_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= 1'b0;
      opnd_q  <= '0;
      acc_q   <= '0;
    end else if (accept) begin
      store_q <= store_d;
      opnd_q  <= opnd_d;
      acc_q   <= acc_d;
    end
  end

  ipi_ptr_unit #(.W(W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (ptr_cap),
    .rdata_i   (mem_rdata_i),
    .ptr_o     (ptr),
    .ptr_inc_o (ptr_inc)
  );

  ipi_bus_drv #(.W(W)) u_bus (
    .phase_i     (phase),
    .store_i     (store_q),
    .opnd_i      (opnd_q),
    .ptr_i       (ptr),
    .ptr_inc_i   (ptr_inc),
    .acc_i       (acc_q),
    .rdata_i     (mem_rdata_i),
    .mem_en_o    (mem_en_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .acc_we_o    (acc_we_o),
    .acc_wdata_o (acc_wdata_o),
    .ptr_cap_o   (ptr_cap)
  );

  assign done_o = (phase == PH_DONE);

  // R1: quiet outside a move
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_en_o && !acc_we_o && !done_o));

  // R2: first access of a move reads the operand location
  p_first_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (mem_en_o && !mem_we_o && (mem_addr_o == opnd_q)));

  // R5: write-back carries the pointer read three cycles earlier, plus one
  p_wb_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PTR_WB) |-> (mem_we_o && (mem_wdata_o == $past(mem_rdata_i, 3) + 8'd1)));

  // R10: stores never strobe the accumulator
  p_store_no_acc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && store_q) |-> !acc_we_o);

  // R10: loads write memory only at the operand address
  p_load_wr_opnd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !store_q && mem_en_o && mem_we_o) |-> (mem_addr_o == opnd_q));

  // R3: accumulator strobe never shares a cycle with a memory access
  p_acc_no_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we_o |-> !mem_en_o);

endmodule

// File: tb/ipi_move_seq_tb.sv
module ipi_move_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic       dir_store_i;
  logic [7:0] opnd_addr_i;
  logic [7:0] acc_i;
  logic       acc_we_o;
  logic [7:0] acc_wdata_o;
  logic       mem_en_o;
  logic       mem_we_o;
  logic [7:0] mem_addr_o;
  logic [7:0] mem_wdata_o;
  logic [7:0] mem_rdata_i;
  logic       busy_o;
  logic       done_o;

  always #2.5 clk = ~clk;  // 200 MHz

  ipi_move_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_store_i(dir_store_i),
    .opnd_addr_i(opnd_addr_i), .acc_i(acc_i), .acc_we_o(acc_we_o),
    .acc_wdata_o(acc_wdata_o), .mem_en_o(mem_en_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o)
  );

  // Memory and accumulator models owned by the bench
  logic [7:0] mem [256];
  logic [7:0] acc_reg;
  int         cyc;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_en_o) begin
      if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
      else          mem_rdata_i     <= mem[mem_addr_o];
    end
    if (acc_we_o) acc_reg <= acc_wdata_o;
  end

  int checks = 0;
  int fails  = 0;
  bit summary_done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    end
  endtask

  typedef struct {
    bit       store;
    bit [7:0] opnd;
    bit [7:0] ptr;
    bit [7:0] exp_acc;
    bit [7:0] exp_dat;
    bit [7:0] exp_ptrloc;
    int       exp_writes;
    int       start_cyc;
  } item_t;

  item_t sb_q[$];
  int    done_seen = 0;
  int    wr_cnt;
  bit [7:0] last_wr;

  always @(negedge clk) begin
    if (rst_n && mem_en_o && mem_we_o) begin
      wr_cnt  = wr_cnt + 1;
      last_wr = mem_addr_o;
    end
  end

  // Monitor: pops the expected item at each done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done_o) begin
        if (sb_q.size() == 0) begin
          chk(0, "R7 unexpected done", 1, 0);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          chk(cyc - it.start_cyc == 9, "R6 done cycle", cyc - it.start_cyc, 9);
          chk(acc_reg == it.exp_acc, it.store ? "R10 acc untouched" : "R3 load acc",
              acc_reg, it.exp_acc);
          chk(mem[it.ptr] == it.exp_dat,
              (it.ptr == it.opnd) ? "R9 alias location" : (it.store ? "R4 store data" : "R10 data untouched"),
              mem[it.ptr], it.exp_dat);
          chk(mem[it.opnd] == it.exp_ptrloc, "R5 pointer write-back", mem[it.opnd], it.exp_ptrloc);
          chk(wr_cnt == it.exp_writes, "R8 write count", wr_cnt, it.exp_writes);
          chk(last_wr == it.opnd, "R8 last write is pointer", last_wr, it.opnd);
        end
        done_seen++;
      end
    end
  end

  // Driver: computes the expected result, starts the move, waits for it
  task automatic do_move(input bit store, input bit [7:0] opnd, input bit [7:0] accv,
                         input bit retrigger);
    item_t it;
    int    target;
    it.store      = store;
    it.opnd       = opnd;
    it.ptr        = mem[opnd];
    it.exp_acc    = store ? acc_reg : mem[mem[opnd]];
    it.exp_dat    = store ? accv : mem[mem[opnd]];
    it.exp_ptrloc = mem[opnd] + 8'd1;
    if (it.ptr == opnd) it.exp_dat = it.exp_ptrloc;
    it.exp_writes = store ? 2 : 1;
    target        = done_seen + 1;

    @(negedge clk);
    start_i = 1'b1; dir_store_i = store; opnd_addr_i = opnd; acc_i = accv;
    @(negedge clk);
    start_i = 1'b0;
    it.start_cyc = cyc;
    wr_cnt = 0;
    sb_q.push_back(it);
    chk(busy_o == 1'b1, "R2 busy after accept", busy_o, 1);
    chk(mem_en_o && !mem_we_o && mem_addr_o == opnd, "R2 first read of operand",
        mem_addr_o, opnd);
    // Scramble inputs after acceptance: they must have no effect (R4)
    acc_i = ~accv; opnd_addr_i = ~opnd; dir_store_i = ~store;
    if (retrigger) begin
      repeat (2) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (done_seen < target) @(negedge clk);
    @(negedge clk);
    chk(busy_o == 1'b0, "R6 busy falls after done", busy_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; dir_store_i = 1'b0; opnd_addr_i = '0; acc_i = '0;
    cyc = 0; acc_reg = 8'h5A; wr_cnt = 0; last_wr = '0; mem_rdata_i = '0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !mem_en_o && !acc_we_o, "R1 in reset",
        {busy_o, done_o, mem_en_o, acc_we_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !done_o && !mem_en_o && !acc_we_o, "R1 after reset",
        {busy_o, done_o, mem_en_o, acc_we_o}, 0);

    // R3 plain load
    mem[8'h10] = 8'h40; mem[8'h40] = 8'hA5;
    do_move(0, 8'h10, 8'h00, 0);
    // R4 plain store
    mem[8'h11] = 8'h80;
    do_move(1, 8'h11, 8'h3C, 0);
    // R5 wrap on load and store
    mem[8'h12] = 8'hFF; mem[8'hFF] = 8'hC3;
    do_move(0, 8'h12, 8'h00, 0);
    mem[8'h13] = 8'hFF;
    do_move(1, 8'h13, 8'h77, 0);
    // R9 alias store and alias load
    mem[8'h20] = 8'h20;
    do_move(1, 8'h20, 8'h99, 0);
    mem[8'h30] = 8'h30;
    do_move(0, 8'h30, 8'h00, 0);
    // R5 walking loads: pointer used before increment
    mem[8'h05] = 8'h60;
    mem[8'h60] = 8'h11; mem[8'h61] = 8'h22; mem[8'h62] = 8'h33;
    for (int k = 0; k < 3; k++) do_move(0, 8'h05, 8'h00, 0);
    chk(mem[8'h05] == 8'h63, "R5 walked pointer", mem[8'h05], 8'h63);
    // Walking stores
    mem[8'hFE] = 8'hFE;
    mem[8'h00] = 8'hA0;
    for (int k = 0; k < 3; k++) do_move(1, 8'h00, 8'(8'hB0 + k), 0);
    chk(mem[8'hA1] == 8'hB1, "R4 walked store", mem[8'hA1], 8'hB1);
    // R7 retrigger during a move
    mem[8'h44] = 8'h90; mem[8'h90] = 8'h5E;
    do_move(0, 8'h44, 8'h00, 1);
    repeat (12) begin
      @(negedge clk);
      chk(!done_o && !busy_o && !mem_en_o, "R7 no extra move", {done_o, busy_o, mem_en_o}, 0);
    end
    // Mixed patterns
    for (int k = 0; k < 6; k++) begin
      bit [7:0] o;
      o = 8'(8'hC0 + k * 5);
      mem[o] = 8'(k * 37 + 1);
      do_move(k[0], o, 8'(k * 29 + 9), 0);
    end
    chk(sb_q.size() == 0, "R6 every move completed", sb_q.size(), 0);
    summary();
    $finish;
  end

endmodule